// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This unit draws a 32x32 two-colour hardware cursor over a raster pixel stream. Each incoming pixel arrives with its x/y raster coordinates and its colour. The unit either passes the colour on unchanged or replaces it with one of two cursor colours. The two cursor colours come from an external palette block. The cursor shape is held in two per-row planes. The mask plane decides where the cursor is opaque. The colour-bit plane picks between the two cursor colours where the mask is set.

Software programs the unit over a simple 32-bit register bus. One word sets the cursor position, with x in the upper half and y in the lower half. There are 32 mask row words, 32 colour-bit row words and one miscellaneous control word. Row words are drawn with their most significant bit as the leftmost pixel. After reset the cursor sits far off-screen, so nothing is drawn until software moves it.

The overlay result is registered once. The valid flag and the coordinates travel with it, so the output stream is a copy of the input stream delayed by one cycle. There is no frame-boundary shadowing: a register write changes the very next pixel that is processed.

Top module: `cursor_overlay`

## Requirements
- R1: After reset both cursor coordinates are 0xF000. No pixel of a 640-wide line is replaced until the position register is written, even when every mask bit is 1.
- R2: A write to offset 0x8FC sets cursor x from write-data bits 31:16 and cursor y from bits 15:0.
- R3: Mask row words sit at offsets 0x900..0x97F and colour-bit row words at 0x980..0x9FF. The cursor row written is (offset - base) >> 2.
- R4: Within a row word, bit 31 is the leftmost cursor pixel (pixel column cx). Column cx+k uses bit 31-k.
- R5: Where the mask bit is 0 the input colour passes through. Where it is 1 the output is color_b if the colour bit is 1, and color_a if it is 0.
- R6: The cursor covers rows cy to cy+31 inclusive. It has no wrap-around past coordinate 0xFFFF.
- R7: The cursor covers columns cx to cx+31, clipped to x < line_width. Nothing is drawn when cx >= line_width.
- R8: A read of offset 0x818 returns the stored miscellaneous word with bit 25 forced to 1. Every other read returns 0. Read data is combinational while rd_en is high.
- R9: out_valid, out_x, out_y and out_color follow pix_valid, pix_x, pix_y and the overlay result with exactly one cycle of latency.
- R10: A register write takes effect for the pixel presented in the cycle after the write cycle. A pixel presented in the same cycle as the write still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| line_width | input | 16 | Active pixels per line |
| color_a | input | 24 | Cursor colour used where the colour bit is 0 |
| color_b | input | 24 | Cursor colour used where the colour bit is 1 |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_color | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel row |
| out_color | output | 24 | Output pixel colour after overlay |

## Verification
The bench goes after the cursor window edges: the last row and column inside the window, and the first ones outside it. A window test that is off by one would paint a 33rd row or column, or drop the 32nd. It places the cursor partly past the right edge and exactly at line_width. A design that clips wrongly would draw beyond the line or draw a cursor that should be hidden. It places a cursor near y = 0xFFF0 and probes small y values. A truncated subtraction there would wrap the cursor onto the top rows. It also checks mask-0 holes at both ends of a row, which catch a reversed bit order. It lands a write in the same cycle as a pixel, which exposes a design that bypasses or delays register updates.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
    localparam logic [11:0] REG_MISC      = 12'h818;
    localparam logic [11:0] REG_POS       = 12'h8FC;
    localparam logic [11:0] REG_MASK_BASE = 12'h900;
    localparam logic [11:0] REG_BITS_BASE = 12'h980;
    localparam int          MISC_ONE_BIT  = 25;
    localparam logic [15:0] POS_OFFSCREEN = 16'hF000;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_overlay_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int COORD_W = 16,
    parameter int CUR_DIM = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    output logic [COORD_W-1:0]               cur_x,
    output logic [COORD_W-1:0]               cur_y,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0]  mask_rows,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0]  bits_rows
);
    localparam int IDX_W      = $clog2(CUR_DIM);
    localparam int PLANE_SPAN = CUR_DIM * 4;

    localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'(REG_MISC);
    localparam logic [ADDR_W-1:0] A_POS   = ADDR_W'(REG_POS);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(REG_MASK_BASE);
    localparam logic [ADDR_W-1:0] A_BITS  = ADDR_W'(REG_BITS_BASE);
    localparam logic [ADDR_W-1:0] A_MASKE = ADDR_W'(REG_MASK_BASE) + ADDR_W'(PLANE_SPAN);
    localparam logic [ADDR_W-1:0] A_BITSE = ADDR_W'(REG_BITS_BASE) + ADDR_W'(PLANE_SPAN);

    typedef struct packed {
        logic [COORD_W-1:0]              px;
        logic [COORD_W-1:0]              py;
        logic [DATA_W-1:0]               misc;
        logic [CUR_DIM-1:0][CUR_DIM-1:0] mask;
        logic [CUR_DIM-1:0][CUR_DIM-1:0] bits;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             hit_mask, hit_bits;
    logic [IDX_W-1:0] mask_idx, bits_idx;

    always_comb begin
        hit_mask = (addr >= A_MASK) && (addr < A_MASKE);
        hit_bits = (addr >= A_BITS) && (addr < A_BITSE);
        mask_idx = IDX_W'((addr - A_MASK) >> 2);
        bits_idx = IDX_W'((addr - A_BITS) >> 2);

        regs_d = regs_q;
        if (wr_en) begin
            if (addr == A_POS) begin
                regs_d.px = wdata[16 +: COORD_W];
                regs_d.py = wdata[0 +: COORD_W];
            end else if (addr == A_MISC) begin
                regs_d.misc = wdata;
            end else if (hit_mask) begin
                regs_d.mask[mask_idx] = wdata[CUR_DIM-1:0];
            end else if (hit_bits) begin
                regs_d.bits[bits_idx] = wdata[CUR_DIM-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.px   <= COORD_W'(POS_OFFSCREEN);
            regs_q.py   <= COORD_W'(POS_OFFSCREEN);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && addr == A_MISC) begin
            rdata = regs_q.misc;
            rdata[MISC_ONE_BIT] = 1'b1;
        end
    end

    assign cur_x     = regs_q.px;
    assign cur_y     = regs_q.py;
    assign mask_rows = regs_q.mask;
    assign bits_rows = regs_q.bits;

    // R8
    misc_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_MISC) |-> rdata[MISC_ONE_BIT]);

    // R8
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != A_MISC) |-> (rdata == '0));

    // R2
    pos_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_POS) |=> (cur_x == $past(wdata[16 +: COORD_W])
                                      && cur_y == $past(wdata[0 +: COORD_W])));
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
    parameter int COORD_W = 16,
    parameter int CUR_DIM = 32
) (
    input  logic [COORD_W-1:0]               pix_x,
    input  logic [COORD_W-1:0]               pix_y,
    input  logic [COORD_W-1:0]               line_width,
    input  logic [COORD_W-1:0]               cur_x,
    input  logic [COORD_W-1:0]               cur_y,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0]  mask_rows,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0]  bits_rows,
    output logic                             cur_on,
    output logic                             cur_sel_b
);
    localparam int IDX_W = $clog2(CUR_DIM);

    logic [COORD_W:0]  dx, dy;
    logic              in_cols, in_rows;
    logic [IDX_W-1:0]  row, col, bitpos;

    always_comb begin
        dx = {1'b0, pix_x} - {1'b0, cur_x};
        dy = {1'b0, pix_y} - {1'b0, cur_y};
        in_rows = (pix_y >= cur_y) && (dy < (COORD_W+1)'(CUR_DIM));
        in_cols = (cur_x < line_width) && (pix_x < line_width)
                  && (pix_x >= cur_x) && (dx < (COORD_W+1)'(CUR_DIM));
        row    = dy[IDX_W-1:0];
        col    = dx[IDX_W-1:0];
        bitpos = IDX_W'(CUR_DIM - 1) - col;
        cur_on    = in_rows && in_cols && mask_rows[row][bitpos];
        cur_sel_b = bits_rows[row][bitpos];
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int COORD_W = 16,
    parameter int PIX_W   = 24,
    parameter int CUR_DIM = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [COORD_W-1:0]  line_width,
    input  logic [PIX_W-1:0]    color_a,
    input  logic [PIX_W-1:0]    color_b,
    input  logic                pix_valid,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [PIX_W-1:0]    pix_color,
    output logic                out_valid,
    output logic [COORD_W-1:0]  out_x,
    output logic [COORD_W-1:0]  out_y,
    output logic [PIX_W-1:0]    out_color
);
    logic [COORD_W-1:0]              cur_x, cur_y;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] mask_rows, bits_rows;
    logic                            cur_on, cur_sel_b;

    cursor_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .COORD_W(COORD_W),
        .CUR_DIM(CUR_DIM)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .mask_rows(mask_rows),
        .bits_rows(bits_rows)
    );

    cursor_hit #(
        .COORD_W(COORD_W),
        .CUR_DIM(CUR_DIM)
    ) u_hit (
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .line_width(line_width),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .mask_rows (mask_rows),
        .bits_rows (bits_rows),
        .cur_on    (cur_on),
        .cur_sel_b (cur_sel_b)
    );

    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [PIX_W-1:0]   color;
    } stage_t;

    stage_t out_d, out_q;

    always_comb begin
        out_d.valid = pix_valid;
        out_d.x     = pix_x;
        out_d.y     = pix_y;
        out_d.color = pix_color;
        if (pix_valid && cur_on) begin
            out_d.color = cur_sel_b ? color_b : color_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_x     = out_q.x;
    assign out_y     = out_q.y;
    assign out_color = out_q.color;

    // R9
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    // R9
    idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R9
    coord_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (out_x == $past(pix_x) && out_y == $past(pix_y)));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cur_on) |=> (out_color == $past(pix_color)));

    // R7
    clip_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_on |-> (pix_x < line_width && cur_x < line_width));

    // R6
    row_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_on |-> (pix_y >= cur_y));
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
    localparam int WIDTH = 640;
    localparam logic [23:0] PIXC = 24'h123456;
    localparam logic [23:0] COLA = 24'hA0A0A0;
    localparam logic [23:0] COLB = 24'hB0B0B0;

    // {cursor x, cursor y, pixel x, pixel y, expected: 0 pass, 1 colour A, 2 colour B}
    localparam int NVEC = 17;
    localparam logic [65:0] VEC [NVEC] = '{
        {16'd100, 16'd50, 16'd100, 16'd50, 2'd2},   // R4 leftmost bit 31
        {16'd100, 16'd50, 16'd101, 16'd50, 2'd1},   // R4
        {16'd100, 16'd50, 16'd131, 16'd81, 2'd1},   // R6 R7 last row/col
        {16'd100, 16'd50, 16'd132, 16'd50, 2'd0},   // R7
        {16'd100, 16'd50, 16'd100, 16'd82, 2'd0},   // R6
        {16'd100, 16'd50, 16'd99,  16'd50, 2'd0},   // R7
        {16'd100, 16'd50, 16'd100, 16'd49, 2'd0},   // R6
        {16'd100, 16'd50, 16'd100, 16'd55, 2'd0},   // R5 mask hole left
        {16'd100, 16'd50, 16'd131, 16'd55, 2'd0},   // R5 mask hole right
        {16'd100, 16'd50, 16'd102, 16'd55, 2'd2},   // R5
        {16'd630, 16'd10, 16'd639, 16'd10, 2'd1},   // R7 partly off right
        {16'd630, 16'd10, 16'd640, 16'd10, 2'd0},   // R7 clip
        {16'd640, 16'd10, 16'd640, 16'd10, 2'd0},   // R7 cx at width
        {16'd0,   16'd0,  16'd0,   16'd0,  2'd2},   // R2 corner
        {16'hF000,16'hF000,16'hF000,16'hF000,2'd0}, // R7 off-screen
        {16'd0, 16'hFFF0, 16'd0, 16'hFFFF, 2'd2},   // R6 near top of range
        {16'd0, 16'hFFF0, 16'd0, 16'h000F, 2'd0}    // R6 no wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [15:0] line_width = 16'(WIDTH);
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [23:0] pix_color = PIXC;
    logic        out_valid;
    logic [15:0] out_x, out_y;
    logic [23:0] out_color;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mask [32];
    logic [31:0] m_bits [32];

    always #10 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_width(line_width), .color_a(COLA), .color_b(COLB),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_color(out_color)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] sel_color(input logic [1:0] s);
        return (s == 2'd2) ? COLB : (s == 2'd1) ? COLA : PIXC;
    endfunction

    function automatic logic [1:0] model_sel(input int cx, input int cy, input int x, input int y);
        int r, c;
        if (cx >= WIDTH || x >= WIDTH || x < cx || x >= cx + 32) return 2'd0;
        if (y < cy || y >= cy + 32) return 2'd0;
        r = y - cy;
        c = x - cx;
        if (!m_mask[r][31-c]) return 2'd0;
        return m_bits[r][31-c] ? 2'd2 : 2'd1;
    endfunction

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] v);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_row(input int r, input logic [31:0] mk, input logic [31:0] bt);
        m_mask[r] = mk;
        m_bits[r] = bt;
        reg_wr(12'h900 + 12'(4 * r), mk);
        reg_wr(12'h980 + 12'(4 * r), bt);
    endtask

    task automatic pix_chk(input string tag, input int x, input int y, input logic [23:0] exp);
        pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y);
        @(negedge clk);
        pix_valid = 1'b0;
        check(tag, {8'h0, out_color}, {8'h0, exp});
    endtask

    task automatic sweep(input string tag, input int cx, input int cy,
                         input int x0, input int x1, input int y0, input int y1);
        reg_wr(12'h8FC, {16'(cx), 16'(cy)});
        for (int y = y0; y <= y1; y++) begin
            for (int x = x0; x <= x1; x++) begin
                pix_chk(tag, x, y, sel_color(model_sel(cx, cy, x, y)));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: full mask, position untouched, top-left pixels pass
        for (int r = 0; r < 32; r++) set_row(r, 32'hFFFF_FFFF, 32'hAAAA_AAAA);
        pix_chk("R1 off-screen at reset (0,0)", 0, 0, PIXC);
        pix_chk("R1 off-screen at reset (639,479)", 639, 479, PIXC);

        // R8 register reads
        reg_rd_en = 1'b1; reg_addr = 12'h818; #1;
        check("R8 misc after reset", reg_rdata, 32'h0200_0000);
        reg_rd_en = 1'b0;
        reg_wr(12'h818, 32'h0000_0011);
        reg_rd_en = 1'b1; reg_addr = 12'h818; #1;
        check("R8 misc stored value", reg_rdata, 32'h0200_0011);
        reg_addr = 12'h8FC; #1;
        check("R8 position reads zero", reg_rdata, 32'h0);
        reg_addr = 12'h900; #1;
        check("R8 mask reads zero", reg_rdata, 32'h0);
        reg_rd_en = 1'b0;
        @(negedge clk);

        // R3 R5: table pattern, row 5 has holes at both ends
        set_row(5, 32'h7FFF_FFFE, 32'hAAAA_AAAA);
        for (int i = 0; i < NVEC; i++) begin
            reg_wr(12'h8FC, {VEC[i][65:50], VEC[i][49:34]});
            pix_valid = 1'b1; pix_x = VEC[i][33:18]; pix_y = VEC[i][17:2];
            @(negedge clk);
            pix_valid = 1'b0;
            check($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", i),
                  {8'h0, out_color}, {8'h0, sel_color(VEC[i][1:0])});
            check($sformatf("R9 out_x vector %0d", i), {16'h0, out_x}, {16'h0, VEC[i][33:18]});
            check($sformatf("R9 out_y vector %0d", i), {16'h0, out_y}, {16'h0, VEC[i][17:2]});
            check($sformatf("R9 out_valid vector %0d", i), {31'h0, out_valid}, 32'h1);
        end
        @(negedge clk);
        check("R9 valid drops one cycle after input", {31'h0, out_valid}, 32'h0);

        // R10: write in same cycle as a pixel sees old position
        reg_wr(12'h8FC, {16'd100, 16'd50});
        reg_wr_en = 1'b1; reg_addr = 12'h8FC; reg_wdata = {16'd300, 16'd50};
        pix_valid = 1'b1; pix_x = 16'd100; pix_y = 16'd50;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R10 same-cycle pixel uses old position", {8'h0, out_color}, {8'h0, COLB});
        pix_x = 16'd300;
        @(negedge clk);
        check("R10 next pixel uses new position", {8'h0, out_color}, {8'h0, COLB});
        pix_x = 16'd100;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R10 old position released", {8'h0, out_color}, {8'h0, PIXC});

        // R3 R4 R5 model sweeps with varied rows
        for (int r = 0; r < 32; r++)
            set_row(r, 32'hFFFF_FFFF >> (r % 8), 32'hC3C3_5A5A ^ (32'h0101_0101 * r));
        sweep("R4 R5 R6 R7 sweep corner", 0, 0, 0, 36, 0, 34);
        sweep("R7 sweep partly off right", WIDTH - 10, 100, WIDTH - 14, WIDTH + 3, 98, 133);
        sweep("R7 sweep at width", WIDTH, 50, WIDTH - 40, WIDTH + 2, 48, 52);
        sweep("R3 R6 sweep interior", 321, 200, 318, 356, 198, 233);
        sweep("R1 R7 sweep off-screen", 16'hF000, 16'hF000, 0, 20, 0, 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule